// File: doc/BRIEF.md
# Boundary-Aware Transfer Splitter

This block takes one block-transfer request and turns it into a sequence of incrementing burst commands for a downstream burst address generator. A request carries a byte start address, a length in beats and a beat size. The block cuts the transfer into chunks, and no chunk reaches past a 1 KB-aligned address region. Each chunk uses the longest fixed incrementing burst that fits: 16, 8 or 4 beats. Where none of those fits, the chunk is a single beat.

Commands leave on a valid/ready handshake. Each one carries its first address, a 3-bit burst-type code, its beat count and the beat size. Each command starts a new burst downstream, so the burst type is declared again on every piece. The block issues a one-cycle completion pulse once the last command of the transfer has been taken. A request with zero length completes at once and issues no command. The start address must be aligned to the beat size.

Top module: `xfer_splitter`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid is 0 and done is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 1 only while no transfer is in progress. Request inputs presented during a transfer are ignored and do not change any command of the current transfer.
- R3: No command spans a 1 KB boundary. The low ten bits of cmd_addr plus cmd_beats times 2^cmd_size never exceed 1024.
- R4: cmd_beats is the largest value in {16, 8, 4, 1} that does not exceed the beats still to be issued and does not exceed the whole beats left before the next 1 KB boundary.
- R5: cmd_burst encodes the beat count as follows: 1 beat is 3'b000, 4 beats is 3'b011, 8 beats is 3'b101 and 16 beats is 3'b111.
- R6: The first command's address equals req_addr. Each later command's address is the previous address plus cmd_beats shifted left by cmd_size. cmd_size equals the request's req_size, where a beat is 2^req_size bytes.
- R7: While cmd_valid is 1 and cmd_ready is 0, cmd_valid stays 1 and every command field holds its value on the next cycle.
- R8: done is 1 for exactly one cycle, the cycle after the handshake of the transfer's final command. In that cycle cmd_valid is 0.
- R9: A request with req_len equal to 0 issues no command. done is 1 in the cycle after the request is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A transfer request is present |
| req_ready | output | 1 | The block is idle and takes a request |
| req_addr | input | ADDR_W | Byte start address, aligned to the beat size |
| req_len | input | LEN_W | Transfer length in beats |
| req_size | input | 2 | Beat size as log2 of the byte count |
| cmd_valid | output | 1 | A burst command is offered |
| cmd_ready | input | 1 | The downstream side takes the command |
| cmd_addr | output | ADDR_W | First byte address of the burst |
| cmd_burst | output | 3 | Burst-type code |
| cmd_beats | output | 5 | Beats in this burst (1, 4, 8 or 16) |
| cmd_size | output | 2 | Beat size as log2 of the byte count |
| done | output | 1 | One-cycle pulse when the whole transfer has been issued |

## Verification
A corrupted address or remaining-beat register shows up on the next command offered. It appears as a wrong cmd_addr, as a burst that spans a 1 KB boundary, or as a wrong beat count, in the same cycle the command becomes valid. A remaining count that is off by any amount changes the number of commands or the size of the last chunk. It also moves the done pulse off the cycle right after the final handshake. A state register stuck in the busy or idle value shows within one cycle, in req_ready, cmd_valid and the absence or duplication of done.

// File: rtl/xfer_split_pkg.sv
package xfer_split_pkg;

    typedef enum logic [2:0] {
        BT_SINGLE = 3'b000,
        BT_INCR4  = 3'b011,
        BT_INCR8  = 3'b101,
        BT_INCR16 = 3'b111
    } burst_code_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } split_state_e;

    localparam int BEATS_W = 5;
    localparam int NUM_FIXED = 3;

endpackage

// File: rtl/xfer_chunk_sel.sv
module xfer_chunk_sel
    import xfer_split_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int BOUND_LOG2 = 10
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [LEN_W-1:0]   rem_i,
    input  logic [1:0]         size_i,
    output logic [BEATS_W-1:0] beats_o,
    output burst_code_e        code_o
);

    localparam int ROOM_W = BOUND_LOG2 + 1;

    logic [ROOM_W-1:0]    room_bytes;
    logic [ROOM_W-1:0]    room_beats;
    logic [NUM_FIXED-1:0] fits;

    always_comb begin
        room_bytes = ROOM_W'(1 << BOUND_LOG2) - ROOM_W'(addr_i[BOUND_LOG2-1:0]);
        room_beats = room_bytes >> size_i;
    end

    // Candidate g is 16 >> g beats: 16, 8, 4.
    for (genvar g = 0; g < NUM_FIXED; g++) begin : g_cand
        localparam int CAND = 16 >> g;
        assign fits[g] = (room_beats >= ROOM_W'(CAND)) && (rem_i >= LEN_W'(CAND));
    end

    always_comb begin
        if (fits[0]) begin
            beats_o = BEATS_W'(16);
            code_o  = BT_INCR16;
        end else if (fits[1]) begin
            beats_o = BEATS_W'(8);
            code_o  = BT_INCR8;
        end else if (fits[2]) begin
            beats_o = BEATS_W'(4);
            code_o  = BT_INCR4;
        end else begin
            beats_o = BEATS_W'(1);
            code_o  = BT_SINGLE;
        end
    end

endmodule

// File: rtl/xfer_advance.sv
module xfer_advance
    import xfer_split_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [LEN_W-1:0]   rem_i,
    input  logic [1:0]         size_i,
    input  logic [BEATS_W-1:0] beats_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic [LEN_W-1:0]   rem_o,
    output logic               last_o
);

    logic [ADDR_W-1:0] step_bytes;

    always_comb begin
        step_bytes = ADDR_W'(beats_i) << size_i;
        addr_o     = addr_i + step_bytes;
        rem_o      = rem_i - LEN_W'(beats_i);
        last_o     = (rem_o == '0);
    end

endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
    import xfer_split_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int BOUND_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [1:0]        req_size,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [2:0]        cmd_burst,
    output logic [4:0]        cmd_beats,
    output logic [1:0]        cmd_size,
    output logic              done
);

    typedef struct packed {
        split_state_e      st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic [1:0]        size;
        logic              done;
    } split_regs_t;

    split_regs_t r_d, r_q;

    logic [BEATS_W-1:0] chunk_beats;
    burst_code_e        chunk_code;
    logic [ADDR_W-1:0]  adv_addr;
    logic [LEN_W-1:0]   adv_rem;
    logic               adv_last;

    xfer_chunk_sel #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .BOUND_LOG2(BOUND_LOG2)
    ) i_chunk_sel (
        .addr_i (r_q.addr),
        .rem_i  (r_q.rem),
        .size_i (r_q.size),
        .beats_o(chunk_beats),
        .code_o (chunk_code)
    );

    xfer_advance #(
        .ADDR_W(ADDR_W),
        .LEN_W (LEN_W)
    ) i_advance (
        .addr_i (r_q.addr),
        .rem_i  (r_q.rem),
        .size_i (r_q.size),
        .beats_i(chunk_beats),
        .addr_o (adv_addr),
        .rem_o  (adv_rem),
        .last_o (adv_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_len == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st   = ST_BUSY;
                        r_d.addr = req_addr;
                        r_d.rem  = req_len;
                        r_d.size = req_size;
                    end
                end
            end
            ST_BUSY: begin
                if (cmd_ready) begin
                    r_d.addr = adv_addr;
                    r_d.rem  = adv_rem;
                    if (adv_last) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, rem: '0, size: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign cmd_valid = (r_q.st == ST_BUSY);
    assign cmd_addr  = r_q.addr;
    assign cmd_burst = chunk_code;
    assign cmd_beats = chunk_beats;
    assign cmd_size  = r_q.size;
    assign done      = r_q.done;

    // Checks on the port behaviour
    logic [BOUND_LOG2+8:0] ast_end;
    assign ast_end = (BOUND_LOG2+9)'(cmd_addr[BOUND_LOG2-1:0])
                   + ((BOUND_LOG2+9)'(cmd_beats) << cmd_size);

    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ast_end <= (BOUND_LOG2+9)'(1 << BOUND_LOG2)); // R3

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)
            && $stable(cmd_beats) && $stable(cmd_burst) && $stable(cmd_size))); // R7

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (!cmd_valid
            || cmd_addr == $past(cmd_addr) + (ADDR_W'($past(cmd_beats)) << $past(cmd_size)))); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && !cmd_valid)); // R8

    AST_BEATS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($countones(cmd_beats) == 1 && cmd_beats != 5'd2)); // R4

    AST_BUSY_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> r_q.rem >= LEN_W'(cmd_beats)); // R4

endmodule

// File: tb/test_xfer_splitter.sv
module test_xfer_splitter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic [1:0]  req_size = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [31:0] cmd_addr;
    logic [2:0]  cmd_burst;
    logic [4:0]  cmd_beats;
    logic [1:0]  cmd_size;
    logic        done;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    xfer_splitter i_xfer_splitter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_size(req_size),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_burst(cmd_burst), .cmd_beats(cmd_beats),
        .cmd_size(cmd_size), .done(done)
    );

    // {addr, len, size}
    localparam logic [49:0] VEC [0:5] = '{
        {32'h0000_0000, 16'd16,   2'd2},
        {32'h0000_03F0, 16'd8,    2'd2},
        {32'h0000_0000, 16'd1024, 2'd2},
        {32'h0000_0100, 16'd7,    2'd0},
        {32'h0000_03F8, 16'd3,    2'd3},
        {32'h1234_5600, 16'd29,   2'd1}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_beats(input logic [31:0] a, input int rem, input int sz);
        int room;
        int av;
        room = (1024 - int'(a[9:0])) >> sz;
        av = (room < rem) ? room : rem;
        if (av >= 16) return 16;
        if (av >= 8) return 8;
        if (av >= 4) return 4;
        return 1;
    endfunction

    function automatic logic [2:0] exp_code(input int b);
        case (b)
            16: return 3'b111;
            8: return 3'b101;
            4: return 3'b011;
            default: return 3'b000;
        endcase
    endfunction

    task automatic run_xfer(input logic [31:0] a, input int len, input int sz, input bit stall);
        logic [31:0] m_addr;
        int m_rem;
        int b;
        @(negedge clk);
        check(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_len = 16'(len); req_size = 2'(sz);
        @(negedge clk);
        req_valid = 1'b0;
        if (len == 0) begin
            check(done == 1'b1, "R9 done on zero length", done, 1);
            check(cmd_valid == 1'b0, "R9 no command", cmd_valid, 0);
            @(negedge clk);
            check(done == 1'b0, "R8 done one cycle", done, 0);
            return;
        end
        m_addr = a;
        m_rem = len;
        while (m_rem > 0) begin
            b = exp_beats(m_addr, m_rem, sz);
            check(cmd_valid == 1'b1, "R2 command offered", cmd_valid, 1);
            check(cmd_addr == m_addr && cmd_size == 2'(sz), "R6 address/size", cmd_addr, m_addr);
            check(cmd_beats == 5'(b), "R4 beat count", cmd_beats, b);
            check(cmd_burst == exp_code(b), "R5 burst code", cmd_burst, exp_code(b));
            check(int'(cmd_addr[9:0]) + (int'(cmd_beats) << cmd_size) <= 1024,
                  "R3 boundary", cmd_addr, m_addr);
            check(done == 1'b0, "R8 no early done", done, 0);
            if (stall) begin
                cmd_ready = 1'b0;
                req_valid = 1'b1; req_addr = 32'hDEAD_0000; req_len = 16'd1; req_size = 2'd0;
                @(negedge clk);
                check(req_ready == 1'b0, "R2 busy not ready", req_ready, 0);
                check(cmd_valid && cmd_addr == m_addr && cmd_beats == 5'(b)
                      && cmd_burst == exp_code(b), "R7 hold under stall", cmd_addr, m_addr);
                req_valid = 1'b0;
                cmd_ready = 1'b1;
            end
            @(negedge clk);
            m_addr = m_addr + (32'(b) << sz);
            m_rem = m_rem - b;
        end
        check(done == 1'b1, "R8 done after last", done, 1);
        check(cmd_valid == 1'b0, "R8 valid low at done", cmd_valid, 0);
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", done, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        check(cmd_valid == 1'b0, "R1 reset valid", cmd_valid, 0);
        check(done == 1'b0, "R1 reset done", done, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 6; i++) begin
            run_xfer(VEC[i][49:18], int'(VEC[i][17:2]), int'(VEC[i][1:0]), 1'b0);
        end

        // Corner cases
        run_xfer(32'h0000_2000, 0, 2, 1'b0);            // R9
        run_xfer(32'h0000_07E0, 12, 2, 1'b1);           // R7, R2 under stall
        run_xfer(32'h0000_0BFC, 1, 2, 1'b0);            // single at boundary edge
        run_xfer(32'h0000_0000, 0, 0, 1'b0);            // R9 back to back

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule